// File: doc/BRIEF.md
# Guard-Skipping Phase Accumulator

This block keeps a running phase for an OFDM receiver. The phase feeds a derotator, or it serves as the fractional-timing word of an interpolator controller. A signed frequency-offset word is captured once per symbol. Every accepted sample in the useful part of a symbol adds that word to the phase.

Samples that fall inside the guard interval are discarded downstream, so the accumulator does not step on them. It only remembers that a guard interval went by. On the first useful sample after a guard, it adds the normal step plus the whole phase that the guard would have accumulated. Because every guard length is a power of two, that missing phase is the offset word shifted left by log2 of the guard length. No multiplier is used. The phase afterwards is the same as that of an accumulator that stepped on every sample.

Seen as a fractional timing word in [-0.5, 0.5) of a sample, the phase wraps modulo one sample. Each wrap raises a one-cycle advance or retard pulse, which tells the interpolator to shift its sample set. The pulse is found from the two top bits of a sum that is one bit wider than the phase.

Top module: `nco_gi_accum`

## Requirements
- R1: While `rst_n` is low at a rising edge, the phase becomes 0, both pulses become 0, the stored offset becomes 0 and no guard interval is pending.
- R2: A `sym_start` pulse captures `freq_i`, `fft_log2` and `gi_sel` for the symbol. Changes on these three inputs at any other time have no effect on the phase or the pulses.
- R3: A useful sample (`smp_vld`=1, `guard_i`=0) with no guard interval pending adds the captured offset, sign-extended, to the PHASE_W-bit phase modulo 2^PHASE_W. The new phase is on `phase_o` after that rising edge.
- R4: A guard sample (`smp_vld`=1, `guard_i`=1) leaves `phase_o` unchanged and marks a guard interval as pending.
- R5: The first useful sample while a guard interval is pending adds offset × (1 + 2^S) modulo 2^PHASE_W and clears the pending mark. When exactly 2^S guard samples were given, the phase then equals the sum of the offset over all samples, guard samples included.
- R6: The guard shift is S = fft_log2 + gi_sel − 5. Codes 0, 1, 2 and 3 of `gi_sel` select 1/32, 1/16, 1/8 and 1/4 of the FFT size 2^fft_log2, where fft_log2 is 11, 12 or 13.
- R7: For each useful sample, take the old phase and the step (truncated to PHASE_W bits) as signed numbers and add them. If the signed sum is at least 2^(PHASE_W−1), `adv_o` is 1 for the next cycle. If the sum is below −2^(PHASE_W−1), `ret_o` is 1 for the next cycle. Otherwise both are 0. The two pulses are never 1 together.
- R8: In a cycle with `smp_vld`=0, the phase holds and both pulses are 0 after the edge. After a guard sample, both pulses are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_start | input | 1 | Start-of-symbol pulse; captures offset, FFT size and guard selector |
| freq_i | input | FREQ_W | Signed frequency-offset word per sample |
| fft_log2 | input | 4 | log2 of FFT size (11, 12, 13) |
| gi_sel | input | 2 | Guard fraction code: 0=1/32, 1=1/16, 2=1/8, 3=1/4 |
| smp_vld | input | 1 | Sample strobe |
| guard_i | input | 1 | High while the current sample belongs to the guard interval |
| phase_o | output | PHASE_W | Wrapped phase / fractional timing word |
| adv_o | output | 1 | One-cycle pulse: phase wrapped past +0.5 |
| ret_o | output | 1 | One-cycle pulse: phase wrapped below −0.5 |

## Verification
Every result of a sample appears exactly one rising edge after the edge that takes the sample. This holds for the stepped phase, the held phase, the guard jump and both pulses. The stored offset and shift apply from the first sample edge after the `sym_start` edge. The bench updates its expected state at the same rising edge that the design uses. It compares the outputs on the falling edge that follows, so each comparison sees the values that edge produced. A second model steps on every sample, guard samples included. It is compared only on cycles right after a useful sample, and this proves that phase continuity is restored at the first useful sample.

// File: rtl/nco_gi_pkg.sv
// Package: shared constants and helpers for the guard-skipping accumulator.
// Assumes fft_log2 is at least GI_MIN_LOG2 so the shift never underflows.
package nco_gi_pkg;
    localparam int GI_MIN_LOG2 = 5;   // smallest guard is 1/32 of the FFT size
    localparam int SH_W        = 5;   // width of the guard-shift amount

    typedef enum logic [1:0] {
        GI_FRAC_32 = 2'd0,
        GI_FRAC_16 = 2'd1,
        GI_FRAC_8  = 2'd2,
        GI_FRAC_4  = 2'd3
    } gi_frac_e;

    // log2 of the guard length in samples
    function automatic logic [SH_W-1:0] guard_shift(input logic [3:0] fft_l2,
                                                    input gi_frac_e   frac);
        return {1'b0, fft_l2} + {3'b000, frac} - SH_W'(GI_MIN_LOG2);
    endfunction
endpackage

// File: rtl/nco_sym_ctl.sv
// Per-symbol control: captures the offset and the guard shift at symbol
// start, and remembers whether guard samples passed since the last useful one.
// Assumes sym_start and the symbol inputs are valid in the same cycle.
module nco_sym_ctl
    import nco_gi_pkg::*;
#(
    parameter int FREQ_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_start,
    input  logic signed [FREQ_W-1:0] freq_i,
    input  logic [3:0]               fft_log2,
    input  logic [1:0]               gi_sel,
    input  logic                     smp_vld,
    input  logic                     guard_i,
    output logic signed [FREQ_W-1:0] freq_q,
    output logic [SH_W-1:0]          shift_q,
    output logic                     pend_q,
    output logic                     useful_smp
);
    assign useful_smp = smp_vld && !guard_i;

    // capture symbol constants
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q  <= '0;
            shift_q <= '0;
        end else if (sym_start) begin
            freq_q  <= freq_i;
            shift_q <= guard_shift(fft_log2, gi_frac_e'(gi_sel));
        end
    end

    // guard-pending flag: set on guard samples, cleared by a useful sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (smp_vld)
            pend_q <= guard_i;
    end
endmodule

// File: rtl/nco_gi_predict.sv
// Step generator: a normal step is the sign-extended offset. On the first
// useful sample after a guard it also adds the offset shifted by the guard
// log2, which stands for the whole skipped phase. Purely combinational.
module nco_gi_predict
    import nco_gi_pkg::*;
#(
    parameter int FREQ_W  = 12,
    parameter int PHASE_W = 16
) (
    input  logic signed [FREQ_W-1:0]  freq_q,
    input  logic [SH_W-1:0]           shift_q,
    input  logic                      pend_q,
    output logic [PHASE_W-1:0]        step_o
);
    logic [PHASE_W-1:0] freq_ext;
    logic [PHASE_W-1:0] jump;

    // sign-extend offset to phase width
    always_comb freq_ext = PHASE_W'(freq_q);

    // guard phase = offset x 2^shift, done by shifting
    always_comb jump = pend_q ? (freq_ext << shift_q) : '0;

    always_comb step_o = freq_ext + jump;
endmodule

// File: rtl/nco_range_chk.sv
// Range detector: adds step to phase in a word one bit wider than the phase.
// The two top bits tell whether the fraction left [-0.5, 0.5). Dropping the
// top bit re-centres the phase by one sample.
module nco_range_chk #(
    parameter int PHASE_W = 16
) (
    input  logic [PHASE_W-1:0] phase_q,
    input  logic [PHASE_W-1:0] step_i,
    output logic [PHASE_W-1:0] sum_o,
    output logic               adv_d,
    output logic               ret_d
);
    localparam int EXT_W = PHASE_W + 1;
    logic [EXT_W-1:0] ext_sum;

    // widened signed sum
    always_comb ext_sum = {phase_q[PHASE_W-1], phase_q} + {step_i[PHASE_W-1], step_i};

    // two-MSB window test
    always_comb begin
        adv_d = (ext_sum[EXT_W-1 -: 2] == 2'b01);
        ret_d = (ext_sum[EXT_W-1 -: 2] == 2'b10);
        sum_o = ext_sum[PHASE_W-1:0];
    end
endmodule

// File: rtl/nco_gi_accum.sv
// Top: guard-skipping phase accumulator. Holds during the guard interval
// and catches up in one step at the first useful sample. Assumes the offset
// is constant within a symbol and the guard holds exactly 2^shift samples.
module nco_gi_accum
    import nco_gi_pkg::*;
#(
    parameter int FREQ_W  = 12,
    parameter int PHASE_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_start,
    input  logic signed [FREQ_W-1:0] freq_i,
    input  logic [3:0]               fft_log2,
    input  logic [1:0]               gi_sel,
    input  logic                     smp_vld,
    input  logic                     guard_i,
    output logic [PHASE_W-1:0]       phase_o,
    output logic                     adv_o,
    output logic                     ret_o
);
    logic signed [FREQ_W-1:0] freq_q;
    logic [SH_W-1:0]          shift_q;
    logic                     pend_q;
    logic                     useful_smp;
    logic [PHASE_W-1:0]       step;
    logic [PHASE_W-1:0]       next_phase;
    logic                     adv_d;
    logic                     ret_d;
    logic [PHASE_W-1:0]       phase_q;

    nco_sym_ctl #(.FREQ_W(FREQ_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_start  (sym_start),
        .freq_i     (freq_i),
        .fft_log2   (fft_log2),
        .gi_sel     (gi_sel),
        .smp_vld    (smp_vld),
        .guard_i    (guard_i),
        .freq_q     (freq_q),
        .shift_q    (shift_q),
        .pend_q     (pend_q),
        .useful_smp (useful_smp)
    );

    nco_gi_predict #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_pred (
        .freq_q  (freq_q),
        .shift_q (shift_q),
        .pend_q  (pend_q),
        .step_o  (step)
    );

    nco_range_chk #(.PHASE_W(PHASE_W)) u_rng (
        .phase_q (phase_q),
        .step_i  (step),
        .sum_o   (next_phase),
        .adv_d   (adv_d),
        .ret_d   (ret_d)
    );

    // phase register: advances only on useful samples
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (useful_smp)
            phase_q <= next_phase;
    end

    // sample-set change pulses, one cycle wide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_o <= 1'b0;
            ret_o <= 1'b0;
        end else begin
            adv_o <= useful_smp && adv_d;
            ret_o <= useful_smp && ret_d;
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/nco_gi_accum_chk.sv
// Checker: temporal properties of the accumulator ports, bound to the top.
module nco_gi_accum_chk #(
    parameter int PHASE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_vld,
    input logic               guard_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               adv_o,
    input logic               ret_o
);
    // R1: reset clears phase and pulses
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (phase_o == '0 && !adv_o && !ret_o));

    // R4: guard samples do not move the phase
    a_r4_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && guard_i) |=> $stable(phase_o));

    // R8: no strobe, no change and no pulse
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(phase_o) && !adv_o && !ret_o));

    // R7: pulses are mutually exclusive
    a_r7_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_o && ret_o));

    // R7: a pulse only follows a useful sample
    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o || ret_o) |-> $past(smp_vld && !guard_i));
endmodule

bind nco_gi_accum nco_gi_accum_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .guard_i (guard_i),
    .phase_o (phase_o),
    .adv_o   (adv_o),
    .ret_o   (ret_o)
);

// File: tb/tb_nco_gi_accum.sv
// Bench: a behavioural model updated on each rising edge and compared on
// each falling edge, plus a model that steps on every sample (guard included).
module tb_nco_gi_accum;
    localparam int FW = 12;
    localparam int PW = 16;
    localparam int MASK = (1 << PW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sym_start = 1'b0;
    logic signed [FW-1:0] freq_i = '0;
    logic [3:0]           fft_log2 = 4'd11;
    logic [1:0]           gi_sel = 2'd0;
    logic                 smp_vld = 1'b0;
    logic                 guard_i = 1'b0;
    logic [PW-1:0]        phase_o;
    logic                 adv_o;
    logic                 ret_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_phase = 0, m_ref = 0, m_f = 0, m_sh = 0;
    bit m_pend = 0, m_adv = 0, m_ret = 0, m_useful = 0;
    string m_tag = "R1";

    always #5 clk = ~clk;

    nco_gi_accum #(.FREQ_W(FW), .PHASE_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .sym_start(sym_start), .freq_i(freq_i),
        .fft_log2(fft_log2), .gi_sel(gi_sel), .smp_vld(smp_vld),
        .guard_i(guard_i), .phase_o(phase_o), .adv_o(adv_o), .ret_o(ret_o)
    );

    function automatic int sgn(input int v);
        int w = v & MASK;
        return (w >= (1 << (PW - 1))) ? w - (1 << PW) : w;
    endfunction

    // expected state, advanced at the same edge as the design
    always @(posedge clk) begin
        int step, s;
        if (!rst_n) begin
            m_phase = 0; m_ref = 0; m_f = 0; m_sh = 0;
            m_pend = 0; m_adv = 0; m_ret = 0; m_useful = 0; m_tag = "R1";
        end else begin
            m_useful = 0; m_adv = 0; m_ret = 0;
            if (smp_vld) begin
                m_ref = (m_ref + m_f) & MASK;
                if (guard_i) begin
                    m_pend = 1; m_tag = "R4";
                end else begin
                    step = m_f;
                    if (m_pend) begin
                        step = m_f + m_f * (1 << m_sh); m_tag = "R5 R6";
                    end else m_tag = "R3 R2";
                    s = sgn(m_phase) + sgn(step);
                    m_adv = (s >= (1 << (PW - 1)));
                    m_ret = (s < -(1 << (PW - 1)));
                    m_phase = (m_phase + step) & MASK;
                    m_pend = 0; m_useful = 1;
                end
            end else m_tag = "R8";
            if (sym_start) begin
                m_f = int'(freq_i);
                m_sh = int'(fft_log2) + int'(gi_sel) - 5;
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (int'(phase_o) != m_phase) begin
                n_fail++;
                $display("FAIL %s phase: got %0d expected %0d", m_tag, phase_o, m_phase);
            end
            n_chk++;
            if (adv_o != m_adv || ret_o != m_ret) begin
                n_fail++;
                $display("FAIL R7 pulses (%s): got adv=%0b ret=%0b expected adv=%0b ret=%0b",
                         m_tag, adv_o, ret_o, m_adv, m_ret);
            end
            if (m_useful) begin
                n_chk++;
                if (int'(phase_o) != m_ref) begin
                    n_fail++;
                    $display("FAIL R5 continuity: got %0d expected %0d", phase_o, m_ref);
                end
            end
        end
    end

    task automatic drive(input bit v, input bit g);
        @(negedge clk);
        smp_vld = v; guard_i = g; sym_start = 1'b0;
    endtask

    // one symbol: start pulse, 2^S guard samples, nu useful samples
    task automatic symbol(input int f, input int fl, input int gs, input int nu,
                          input bit scramble);
        int gl;
        @(negedge clk);
        sym_start = 1'b1; smp_vld = 1'b0; guard_i = 1'b0;
        freq_i = FW'(f); fft_log2 = 4'(fl); gi_sel = 2'(gs);
        gl = 1 << (fl - 5 + gs);
        @(negedge clk);
        sym_start = 1'b0;
        if (scramble) begin   // R2: later input changes must not matter
            freq_i = FW'(-f - 7); fft_log2 = 4'd13; gi_sel = 2'(3 - gs);
        end
        for (int i = 0; i < gl; i++) begin
            if (i % 5 == 2) drive(1'b0, 1'b1);
            drive(1'b1, 1'b1);
        end
        for (int i = 0; i < nu; i++) begin
            if (i % 4 == 3) drive(1'b0, 1'b0);
            drive(1'b1, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        symbol(37,    11, 0, 30, 1'b0);
        symbol(-5,    11, 1, 30, 1'b1);
        symbol(2047,  11, 2, 60, 1'b0);
        symbol(-1900, 11, 3, 60, 1'b1);
        symbol(1234,  12, 1, 40, 1'b0);
        symbol(-2048, 13, 3, 50, 1'b1);
        symbol(811,   12, 0, 40, 1'b1);
        // useful samples with no guard in between
        @(negedge clk); sym_start = 1'b1; freq_i = 12'sd999; smp_vld = 1'b0;
        for (int i = 0; i < 80; i++) drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        // reset in the middle of running
        @(negedge clk); rst_n = 1'b0; smp_vld = 1'b1;
        @(negedge clk); rst_n = 1'b1; smp_vld = 1'b0;
        symbol(-333, 11, 2, 20, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule